// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block is a watchdog peripheral on a 16-bit register port. A one-cycle strobe from outside marks each half second. Once software sets the enable bit, the block counts down from the programmed timeout. Software restarts the count by writing a two-word unlock pair to the service register. If the count runs out, the block pulses a timeout reset request. It can also drive an active-low external watchdog line low and keep it low until the next power-on reset. An optional interrupt warns software a programmable number of half seconds before the count runs out.

Software can request a system reset, or drive the external line low, through two active-low control bits. The block stores the cause of the most recent reset in a read-only status register. A timeout or a software reset acts as a warm reset inside the block. It returns every setting that is not locked to its default, reloads the count, and keeps the status register and the locked enable and timeout settings. Three suspend bits, each paired with a mode input, stop the count during low-power, debug or wait states.

Register map (word address on `addr_i`): 0 control, 1 service, 2 reset status, 3 interrupt control, 4 miscellaneous. Control register fields: bit 0 low-power suspend, bit 1 debug suspend, bit 2 enable, bit 3 external-line-on-timeout, bit 4 software reset (active low), bit 5 external-line force (active low), bit 7 wait suspend, bits 15:8 timeout field. Interrupt control register fields: bits 7:0 lead time, bit 14 fired flag, bit 15 interrupt enable. Miscellaneous register: bit 0 is a power-down enable, stored and read back.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` low the control register reads 0x0030, interrupt control 0x0004, reset status 0x0010 and miscellaneous 0x0001. After the same reset `irq_o`, `tmo_rst_o` and `sw_rst_o` are 0 and `wdog_n_o` is 1.
- R2: While control bit 2 is 0 the count does not run. A write that sets bit 2 with timeout field N loads N+1 units. `tmo_rst_o` is high for one cycle in the cycle after the clock edge that takes the (N+1)th unsuspended tick.
- R3: The count reloads to N+1 only when 0x5555 is written to the service register and 0xAAAA is the next service write. 0xAAAA without a pending 0x5555 does nothing. Any other value cancels a pending 0x5555.
- R4: Once bit 2 is 1, writes to bit 2 and to bits 15:8 are ignored until `rst_n`. Before that, the timeout field can be written freely.
- R5: With bit 15 of interrupt control set and lead time L (bits 7:0) not zero, bit 14 is set on the tick that leaves L units remaining. `irq_o` equals bit 14 AND bit 15. Writing 1 to bit 14 clears it. With L = 0 no interrupt is raised.
- R6: Control bits 0, 1 and 7 each stop the count while `lowpwr_i`, `debug_i` or `wait_i` respectively is 1. A suspend bit whose mode input is 0 has no effect.
- R7: With control bit 3 set, `wdog_n_o` goes low in the same cycle as the timeout pulse and stays low until `rst_n`, including after the warm reset. With bit 3 clear, a timeout leaves `wdog_n_o` high.
- R8: Writing 0 to control bit 5 drives `wdog_n_o` low from the next cycle until bit 5 is written 1 or a warm reset occurs.
- R9: A control write with bit 4 = 0 makes `sw_rst_o` high for exactly the next cycle. Bit 4 then reads 1.
- R10: The reset status register has exactly one bit set: 0x0010 after `rst_n`, 0x0002 after a timeout, 0x0001 after a software reset. If both occur in the same cycle, the timeout wins. Writes to it are ignored.
- R11: A timeout or software reset returns control bits 0, 1, 3 and 7 to 0, bits 4 and 5 to 1, and interrupt control to 0x0004. It reloads the count to N+1 and keeps bit 2 and bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle half-second strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address (write and read) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (service register reads 0) |
| lowpwr_i | input | 1 | Low-power mode indicator |
| debug_i | input | 1 | Debug mode indicator |
| wait_i | input | 1 | Wait mode indicator |
| irq_o | output | 1 | Pre-timeout interrupt |
| tmo_rst_o | output | 1 | One-cycle timeout reset request |
| sw_rst_o | output | 1 | One-cycle software reset request |
| wdog_n_o | output | 1 | Active-low external watchdog line |

## Verification
The count is never visible directly, so a wrong count shows up as `tmo_rst_o` firing on the wrong tick. The bench checks the quiet tick just before the expected expiry and the expiry tick itself. That pins the error to within one half-second unit. A faulty unlock sequence shows up as a timeout one service period early or late. A broken lock or warm-reset rule shows up in the first control register read after the event. A stuck interrupt flag shows up on `irq_o` in the cycle after the clearing write.

// File: rtl/wdog_pkg.sv
// Shared constants and the control register layout of the watchdog.
// Assumes a 16-bit register port with word addresses.
package wdog_pkg;
    localparam int DW = 16;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_SVC  = 3'd1;
    localparam logic [AW-1:0] A_STAT = 3'd2;
    localparam logic [AW-1:0] A_ICR  = 3'd3;
    localparam logic [AW-1:0] A_MISC = 3'd4;

    localparam logic [DW-1:0] SVC_KEY_FIRST  = 16'h5555;
    localparam logic [DW-1:0] SVC_KEY_SECOND = 16'hAAAA;

    localparam logic [DW-1:0] STAT_POR = 16'h0010;
    localparam logic [DW-1:0] STAT_TMO = 16'h0002;
    localparam logic [DW-1:0] STAT_SW  = 16'h0001;

    localparam logic [7:0] LEAD_DEFAULT = 8'd4;

    // Control register, bit 15 down to bit 0
    typedef struct packed {
        logic [7:0] tsel;        // timeout field, N -> N+1 half seconds
        logic       wait_stop;   // suspend in wait mode
        logic       rsvd;        // reads 0
        logic       force_n;     // drive external line low when 0
        logic       swrst_n;     // software reset request when written 0
        logic       pin_on_tmo;  // drive external line on timeout
        logic       enable;      // count enable, write-once
        logic       dbg_stop;    // suspend in debug mode
        logic       lp_stop;     // suspend in low-power mode
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{tsel: 8'd0, wait_stop: 1'b0, rsvd: 1'b0,
                                       force_n: 1'b1, swrst_n: 1'b1, pin_on_tmo: 1'b0,
                                       enable: 1'b0, dbg_stop: 1'b0, lp_stop: 1'b0};
endpackage

// File: rtl/wdog_regs.sv
// Register decode, storage and read mux of the watchdog.
// Assumes warm_i is a one-cycle event that overrides any write in the same cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               warm_i,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic               irq_hit_i,
    input  logic [DW-1:0]      stat_i,
    output ctrl_t              ctrl_o,
    output logic [FIELD_W-1:0] lead_o,
    output logic               ie_o,
    output logic               flag_o,
    output logic               en_load_o,
    output logic [FIELD_W-1:0] load_val_o,
    output logic               sw_req_o,
    output logic               svc_wr_o,
    output logic [DW-1:0]      rdata_o
);
    ctrl_t              ctrl_q;
    logic [FIELD_W-1:0] lead_q;
    logic               ie_q;
    logic               flag_q;
    logic               pd_q;
    logic               wr_ctrl, wr_icr, wr_misc;

    // Address decode of write strobes
    always_comb begin
        wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
        wr_icr   = wr_en_i && (addr_i == A_ICR);
        wr_misc  = wr_en_i && (addr_i == A_MISC);
        svc_wr_o = wr_en_i && (addr_i == A_SVC);
    end

    // Events derived from a control write
    always_comb begin
        sw_req_o   = wr_ctrl && !wdata_i[4];
        en_load_o  = wr_ctrl && wdata_i[2] && !ctrl_q.enable && !warm_i;
        load_val_o = wdata_i[15:8];
    end

    // Control register with write-once enable and timeout field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEFAULT;
        end else if (warm_i) begin
            ctrl_q.lp_stop    <= 1'b0;
            ctrl_q.dbg_stop   <= 1'b0;
            ctrl_q.pin_on_tmo <= 1'b0;
            ctrl_q.swrst_n    <= 1'b1;
            ctrl_q.force_n    <= 1'b1;
            ctrl_q.rsvd       <= 1'b0;
            ctrl_q.wait_stop  <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q.lp_stop    <= wdata_i[0];
            ctrl_q.dbg_stop   <= wdata_i[1];
            ctrl_q.pin_on_tmo <= wdata_i[3];
            ctrl_q.swrst_n    <= 1'b1;
            ctrl_q.force_n    <= wdata_i[5];
            ctrl_q.rsvd       <= 1'b0;
            ctrl_q.wait_stop  <= wdata_i[7];
            if (!ctrl_q.enable) begin
                ctrl_q.enable <= wdata_i[2];
                ctrl_q.tsel   <= wdata_i[15:8];
            end
        end
    end

    // Interrupt control: lead time, enable and write-one-to-clear flag
    always_ff @(posedge clk) begin
        if (!rst_n || warm_i) begin
            lead_q <= FIELD_W'(LEAD_DEFAULT);
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_icr) begin
                lead_q <= wdata_i[FIELD_W-1:0];
                ie_q   <= wdata_i[15];
            end
            if (irq_hit_i)
                flag_q <= 1'b1;
            else if (wr_icr && wdata_i[14])
                flag_q <= 1'b0;
        end
    end

    // Miscellaneous register: power-down enable bit, stored only
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_q <= 1'b1;
        else if (wr_misc)
            pd_q <= wdata_i[0];
    end

    // Read mux
    always_comb begin
        unique case (addr_i)
            A_CTRL:  rdata_o = ctrl_q;
            A_STAT:  rdata_o = stat_i;
            A_ICR:   rdata_o = {ie_q, flag_q, {(14-FIELD_W){1'b0}}, lead_q};
            A_MISC:  rdata_o = {{(DW-1){1'b0}}, pd_q};
            default: rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign lead_o = lead_q;
    assign ie_o   = ie_q;
    assign flag_o = flag_q;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.enable |=> ctrl_q.enable && $stable(ctrl_q.tsel))
        else $error("locked fields changed"); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !warm_i && !(wr_icr && wdata_i[14]) |=> flag_q)
        else $error("interrupt flag lost"); // R5
endmodule

// File: rtl/wdog_service.sv
// Two-word unlock sequence on the service register.
// Assumes svc_wr_i marks a write to the service address.
module wdog_service
    import wdog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_i,
    input  logic          svc_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          reload_o
);
    logic armed_q;

    // Second key completes the pair only while armed
    assign reload_o = svc_wr_i && armed_q && (wdata_i == SVC_KEY_SECOND);

    // Arm on first key; any other service write disarms
    always_ff @(posedge clk) begin
        if (!rst_n || warm_i)
            armed_q <= 1'b0;
        else if (svc_wr_i)
            armed_q <= (wdata_i == SVC_KEY_FIRST);
    end

    AST_SVC_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> !armed_q)
        else $error("sequence still armed after reload"); // R3
endmodule

// File: rtl/wdog_counter.sv
// Half-second down counter with expiry and pre-timeout match.
// Assumes tick_i is one cycle wide; the count is nonzero while enabled.
module wdog_counter #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] load_val_i,
    input  logic               reload_i,
    input  logic               warm_i,
    input  logic [FIELD_W-1:0] tsel_i,
    input  logic [FIELD_W-1:0] lead_i,
    input  logic               ie_i,
    output logic               expire_o,
    output logic               irq_hit_o
);
    localparam int CNT_W = FIELD_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dec;
    logic             step;

    // Decrement step and event detection
    always_comb begin
        step      = en_i && run_i && tick_i;
        dec       = cnt_q - CNT_W'(1);
        expire_o  = step && (cnt_q == CNT_W'(1));
        irq_hit_o = step && ie_i && (lead_i != '0) && (dec == CNT_W'(lead_i));
    end

    // Count register: load on enable, reload on service or warm reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CNT_W'(load_val_i) + CNT_W'(1);
        else if (warm_i || reload_i)
            cnt_q <= CNT_W'(tsel_i) + CNT_W'(1);
        else if (step)
            cnt_q <= dec;
    end

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> cnt_q != '0)
        else $error("count zero while enabled"); // R2
    AST_CNT_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || !tick_i) && !load_i && !reload_i && !warm_i |=> $stable(cnt_q))
        else $error("count moved without a tick"); // R6
endmodule

// File: rtl/wdog_timer.sv
// Watchdog top: ties registers, unlock sequence and counter together,
// and owns the reset cause, the request pulses and the external line.
// Assumes rst_n is the power-on reset; timeout and software reset act as warm reset.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          lowpwr_i,
    input  logic          debug_i,
    input  logic          wait_i,
    output logic          irq_o,
    output logic          tmo_rst_o,
    output logic          sw_rst_o,
    output logic          wdog_n_o
);
    ctrl_t              ctrl;
    logic [FIELD_W-1:0] lead, load_val;
    logic               ie, flag, en_load, sw_req, svc_wr, reload;
    logic               expire, irq_hit, warm, run;
    logic [DW-1:0]      stat_q;
    logic               tmo_q, sw_q, pin_lat_q;

    // Suspend qualification and warm reset event
    always_comb begin
        run  = !(ctrl.lp_stop && lowpwr_i) && !(ctrl.dbg_stop && debug_i)
            && !(ctrl.wait_stop && wait_i);
        warm = expire || sw_req;
    end

    wdog_regs #(.FIELD_W(FIELD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .warm_i(warm), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .irq_hit_i(irq_hit), .stat_i(stat_q),
        .ctrl_o(ctrl), .lead_o(lead), .ie_o(ie), .flag_o(flag),
        .en_load_o(en_load), .load_val_o(load_val), .sw_req_o(sw_req),
        .svc_wr_o(svc_wr), .rdata_o(rdata_o)
    );

    wdog_service u_svc (
        .clk(clk), .rst_n(rst_n), .warm_i(warm), .svc_wr_i(svc_wr),
        .wdata_i(wdata_i), .reload_o(reload)
    );

    wdog_counter #(.FIELD_W(FIELD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(ctrl.enable), .run_i(run), .tick_i(tick_i),
        .load_i(en_load), .load_val_i(load_val), .reload_i(reload), .warm_i(warm),
        .tsel_i(ctrl.tsel), .lead_i(lead), .ie_i(ie),
        .expire_o(expire), .irq_hit_o(irq_hit)
    );

    // Reset cause, latched at reset entry; timeout wins over software
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= STAT_POR;
        else if (expire)
            stat_q <= STAT_TMO;
        else if (sw_req)
            stat_q <= STAT_SW;
    end

    // One-cycle reset request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= 1'b0;
            sw_q  <= 1'b0;
        end else begin
            tmo_q <= expire;
            sw_q  <= sw_req;
        end
    end

    // External line latch on timeout, cleared only by power-on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_lat_q <= 1'b0;
        else if (expire && ctrl.pin_on_tmo)
            pin_lat_q <= 1'b1;
    end

    assign tmo_rst_o = tmo_q;
    assign sw_rst_o  = sw_q;
    assign irq_o     = flag && ie;
    assign wdog_n_o  = !(pin_lat_q || !ctrl.force_n);

    AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({stat_q[4], stat_q[1], stat_q[0]}) && ((stat_q & ~16'h0013) == '0))
        else $error("reset status not one-hot"); // R10
    AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pin_lat_q |=> !wdog_n_o)
        else $error("external line released after timeout"); // R7
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
    import wdog_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          lowpwr_i = 1'b0, debug_i = 1'b0, wait_i = 1'b0;
    logic          irq_o, tmo_rst_o, sw_rst_o, wdog_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard queues: requirement tag, observed signal, expected value
    string         q_tag[$];
    int            q_sel[$];
    logic [DW-1:0] q_exp[$];

    localparam int S_RD = 0, S_IRQ = 1, S_PIN = 2, S_TMO = 3, S_SW = 4;

    always #10 clk = ~clk;

    wdog_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .lowpwr_i(lowpwr_i), .debug_i(debug_i), .wait_i(wait_i),
        .irq_o(irq_o), .tmo_rst_o(tmo_rst_o), .sw_rst_o(sw_rst_o), .wdog_n_o(wdog_n_o)
    );

    // Monitor: pops expected items at the falling edge and compares
    always @(negedge clk) begin
        while (q_tag.size() > 0) begin
            string         tag;
            int            sel;
            logic [DW-1:0] exp_v;
            logic [DW-1:0] act;
            tag   = q_tag.pop_front();
            sel   = q_sel.pop_front();
            exp_v = q_exp.pop_front();
            case (sel)
                S_RD:    act = rdata_o;
                S_IRQ:   act = {15'b0, irq_o};
                S_PIN:   act = {15'b0, wdog_n_o};
                S_TMO:   act = {15'b0, tmo_rst_o};
                default: act = {15'b0, sw_rst_o};
            endcase
            checks++;
            if (act !== exp_v) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
            end
        end
    end

    task automatic push(input string tag, input int sel, input logic [DW-1:0] v);
        q_tag.push_back(tag);
        q_sel.push_back(sel);
        q_exp.push_back(v);
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        settle();
        wr_en_i = 1'b0;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        settle();
        tick_i = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] v);
        addr_i = a;
        push(tag, S_RD, v);
        settle();
    endtask

    task automatic chk(input string tag, input int sel, input logic v);
        push(tag, sel, {15'b0, v});
        settle();
    endtask

    task automatic por();
        rst_n = 1'b0;
        settle(); settle();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        por();
        // R1 reset state
        chk_rd("R1 ctrl", A_CTRL, 16'h0030);
        chk_rd("R1 icr", A_ICR, 16'h0004);
        chk_rd("R1 stat", A_STAT, 16'h0010);
        chk_rd("R1 misc", A_MISC, 16'h0001);
        push("R1 pin", S_PIN, 16'h1); push("R1 irq", S_IRQ, 16'h0);
        push("R1 tmo", S_TMO, 16'h0); chk("R1 sw", S_SW, 1'b0);

        // R2 disabled: no count
        for (int i = 0; i < 5; i++) begin tick(); chk("R2 disabled", S_TMO, 1'b0); end

        // R2 enable with N=3: expiry on the 4th tick
        wr(A_CTRL, 16'h0334);
        for (int i = 0; i < 3; i++) begin tick(); chk("R2 before expiry", S_TMO, 1'b0); end
        tick(); chk("R2 expiry", S_TMO, 1'b1);
        chk("R2 single pulse", S_TMO, 1'b0);
        chk_rd("R10 timeout cause", A_STAT, 16'h0002);
        chk_rd("R11 locked fields kept", A_CTRL, 16'h0334);

        // R4 locked fields ignore writes
        wr(A_CTRL, 16'h0830);
        chk_rd("R4 lock", A_CTRL, 16'h0334);

        // R3 correct service pair
        tick(); tick();
        wr(A_SVC, 16'h5555); wr(A_SVC, 16'hAAAA);
        for (int i = 0; i < 3; i++) begin tick(); chk("R3 reloaded", S_TMO, 1'b0); end
        tick(); chk("R3 expiry after reload", S_TMO, 1'b1);

        // R3 wrong order does not reload
        tick(); tick();
        wr(A_SVC, 16'hAAAA); wr(A_SVC, 16'h5555);
        tick(); chk("R3 wrong order", S_TMO, 1'b0);
        tick(); chk("R3 wrong order expiry", S_TMO, 1'b1);

        // R3 other value aborts a pending first key
        tick(); tick();
        wr(A_SVC, 16'h5555); wr(A_SVC, 16'h1234); wr(A_SVC, 16'hAAAA);
        tick(); chk("R3 abort", S_TMO, 1'b0);
        tick(); chk("R3 abort expiry", S_TMO, 1'b1);

        // R5 interrupt with lead 2
        wr(A_ICR, 16'h8002);
        tick(); chk("R5 early", S_IRQ, 1'b0);
        tick(); chk("R5 fire", S_IRQ, 1'b1);
        chk_rd("R5 flag set", A_ICR, 16'hC002);
        wr(A_ICR, 16'hC002);
        chk("R5 cleared", S_IRQ, 1'b0);
        chk_rd("R5 flag clear", A_ICR, 16'h8002);
        tick(); chk("R5 stays clear", S_IRQ, 1'b0);
        tick(); chk("R5 expiry", S_TMO, 1'b1);
        chk_rd("R11 icr default", A_ICR, 16'h0004);

        // R5 lead 0 raises nothing
        wr(A_ICR, 16'h8000);
        for (int i = 0; i < 3; i++) begin tick(); chk("R5 lead zero", S_IRQ, 1'b0); end
        tick(); chk("R5 lead zero expiry", S_TMO, 1'b1);

        // R6 suspend modes
        wr(A_CTRL, 16'h0335); lowpwr_i = 1'b1;
        for (int i = 0; i < 6; i++) begin tick(); chk("R6 lowpower", S_TMO, 1'b0); end
        wr(A_CTRL, 16'h03B6); debug_i = 1'b1; wait_i = 1'b1;
        chk_rd("R6 ctrl", A_CTRL, 16'h03B6);
        for (int i = 0; i < 6; i++) begin tick(); chk("R6 debug", S_TMO, 1'b0); end
        debug_i = 1'b0;
        for (int i = 0; i < 3; i++) begin tick(); chk("R6 wait", S_TMO, 1'b0); end
        wait_i = 1'b0;
        for (int i = 0; i < 3; i++) begin tick(); chk("R6 resumed", S_TMO, 1'b0); end
        tick(); chk("R6 expiry", S_TMO, 1'b1);
        lowpwr_i = 1'b0;

        // R7 external line on timeout, held until power-on reset
        wr(A_CTRL, 16'h033C);
        chk("R7 line idle", S_PIN, 1'b1);
        for (int i = 0; i < 3; i++) tick();
        tick(); push("R7 expiry", S_TMO, 16'h1); chk("R7 line low", S_PIN, 1'b0);
        repeat (5) settle();
        chk("R7 line held", S_PIN, 1'b0);
        chk_rd("R11 bit3 cleared", A_CTRL, 16'h0334);
        por();
        chk("R7 line released", S_PIN, 1'b1);
        chk_rd("R4 unlocked by por", A_CTRL, 16'h0030);
        chk_rd("R10 por cause", A_STAT, 16'h0010);

        // R8 forced external line
        wr(A_CTRL, 16'h0010);
        chk("R8 forced low", S_PIN, 1'b0);
        wr(A_CTRL, 16'h0030);
        chk("R8 released", S_PIN, 1'b1);

        // R9 software reset, also releases a forced line (R11)
        wr(A_CTRL, 16'h0010);
        wr(A_CTRL, 16'h0000);
        push("R9 pulse", S_SW, 16'h1); chk("R11 force cleared", S_PIN, 1'b1);
        chk("R9 single pulse", S_SW, 1'b0);
        chk_rd("R9 ctrl after", A_CTRL, 16'h0030);
        chk_rd("R10 sw cause", A_STAT, 16'h0001);
        wr(A_STAT, 16'h0012);
        chk_rd("R10 read only", A_STAT, 16'h0001);
        wr(A_CTRL, 16'h0530);
        chk_rd("R4 unlocked timeout write", A_CTRL, 16'h0530);

        settle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule